// File: doc/BRIEF.md
# PCM Bit Clock and Frame-Sync Generator

This block times a telephony-style PCM serial port. It runs on one system clock. A reference is given as a tick input: either the primary 15.625 MHz tick or an alternate tick. A programmable divider turns every (N+1) reference ticks into one bit period. The bit clock can instead follow the rising edges of an external clock pin. Each bit period starts with a bit-clock pulse that is high for one system clock. Its falling edge is the start of the next system clock.

The block counts 8 bits per slot and a number of slots per frame that the slot mode sets. It produces a frame-sync output that is short or long and active high or low. In external frame-sync mode it aligns its counters to a frame-sync input instead. It also drives an output enable for the serial data line. The shift logic beside it uses the bit index and slot index outputs.

A small frame state machine tracks the position in the frame. Its states are `ST_IDLE`, `ST_SYNC` and `ST_RUN`. It moves from `ST_IDLE` to `ST_RUN` on the first bit strobe when the frame sync is internal. It moves from `ST_IDLE` to `ST_SYNC` at once when the frame sync is external, and from `ST_SYNC` to `ST_RUN` on the leading edge of the external frame sync. It returns from `ST_SYNC` to `ST_IDLE` when external mode is cleared. Any state returns to `ST_IDLE` on a restart or when no clock source is enabled.

Top module: `pcm_frame_timer`

## Requirements
- R1: With the clock source internal and the divider field set to N, `bclk_o` gives one pulse, one system clock wide, every N+1 selected reference ticks. N = 0 passes every tick straight through. Bit periods must be at least two system clocks long.
- R2: The reference select bit (register 0, bit 6) chooses `alt_tick_i` when set and `ref_tick_i` when clear.
- R3: When the clock-enable bit (register 0, bit 7) is clear and the clock source is internal, no bit pulse occurs and `frame_run` and `dtx_oe` stay low. After reset every configuration bit is 0, so all outputs are low except `fsync_oe`, which is high.
- R4: When the external-clock bit (register 1, bit 0) is set, each rising edge of `ext_bclk_i` gives one bit pulse, whatever the state of the clock-enable bit.
- R5: When the clock-out bit (register 1, bit 1) is clear, `bclk_o` is held low while the bit and slot counters keep advancing.
- R6: Each slot has 8 bits, indexed 0 to 7. A frame has 4 << M slots, where M is the slot mode (register 1, bits 7:6): mode 0 gives 4 slots and 32 bits. With internal frame sync, the first bit period after a start is the last position of a frame (bit 7 of the last slot). Bit 0 of slot 0 follows it.
- R7: The internal frame sync is active for exactly the last bit period of each frame in short mode (register 1, bit 3 clear). In long mode it is active for all 8 bits of slot 0.
- R8: When the polarity bit (register 1, bit 4) is set, the frame sync is active low on `fsync_o`. When it is clear, the frame sync is active high.
- R9: When the external frame-sync bit (register 1, bit 2) is set, `fsync_oe` is low and `fsync_o` is held low. `ext_fsync_i` is sampled at each bit strobe, with the polarity of R8 applied. Its leading edge places the position at the last bit of the frame in short mode and at bit 0 of slot 0 in long mode. Until the first such edge, `frame_run` stays low.
- R10: While the frame runs, `dtx_oe` is high. When the tristate bit (register 1, bit 5) is set, `dtx_oe` goes low from the falling edge of the bit-7 pulse to the end of bit 7. `dtx_oe` is low whenever the frame is not running.
- R11: A write that changes the divider field or the slot mode restarts the frame. The divider and the counters clear, and the next bit period is the pre-frame position of R6.
- R12: Registers are written through `cfg_wr`, `cfg_addr` and `cfg_wdata`. Register 0 holds the divider in bits 5:0, the reference select in bit 6 and the clock enable in bit 7. Register 1 holds external clock (bit 0), clock out (1), external frame sync (2), long frame sync (3), active-low polarity (4), tristate (5) and slot mode (7:6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select (0 = clock, 1 = frame) |
| cfg_wdata | input | 8 | Register write data |
| ref_tick_i | input | 1 | Primary reference tick |
| alt_tick_i | input | 1 | Alternate reference tick |
| ext_bclk_i | input | 1 | External bit clock |
| ext_fsync_i | input | 1 | External frame sync |
| bclk_o | output | 1 | Bit-clock pulse |
| fsync_o | output | 1 | Frame-sync output |
| fsync_oe | output | 1 | Frame-sync pin drive enable |
| dtx_oe | output | 1 | Serial data output enable |
| bit_idx | output | 3 | Bit index inside the slot |
| slot_idx | output | 5 | Slot index inside the frame |
| frame_run | output | 1 | Frame counter running |

## Verification
Each result appears one system clock after the edge that takes the strobe, whether the strobe comes from a reference tick or from an external clock edge. `bclk_o`, `bit_idx`, `slot_idx`, `fsync_o` and `dtx_oe` all change together in the cycle that follows that edge. Register writes take effect at the edge that takes `cfg_wr`. The bench drives inputs and samples outputs at the falling clock edge. For every observed pulse it checks the position and the frame sync against an index it computes as (pulse number + frame length - 1) mod frame length. It measures the bit period as the count of falling edges between pulses, and it checks `dtx_oe` in every cycle between pulses.

// File: rtl/pcm_fs_pkg.sv
package pcm_fs_pkg;
    localparam int DIV_W    = 6;
    localparam int MODE_W   = 2;
    localparam int BIT_W    = 3;
    localparam int BASE_LOG = 2;
    localparam int SLOT_W   = BASE_LOG + (1 << MODE_W) - 1;
    localparam int CFG_W    = DIV_W + 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_RUN  = 2'd2
    } fr_state_e;

    typedef struct packed {
        logic             clk_en;
        logic             ref_alt;
        logic [DIV_W-1:0] div;
    } clk_cfg_t;

    typedef struct packed {
        logic [MODE_W-1:0] slot_mode;
        logic              tri_en;
        logic              fs_low;
        logic              long_fs;
        logic              ext_fs;
        logic              clkout_en;
        logic              ext_clk;
    } frm_cfg_t;
endpackage

// File: rtl/pcm_bclk_src.sv
module pcm_bclk_src #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick_i,
    input  logic             alt_tick_i,
    input  logic             ref_alt,
    input  logic [DIV_W-1:0] div,
    input  logic             clk_en,
    input  logic             ext_clk,
    input  logic             ext_bclk_i,
    input  logic             restart,
    output logic             bit_stb,
    output logic             active,
    output logic             bclk_pulse
);
    logic [DIV_W-1:0] cnt;
    logic             ext_q;
    logic             ref_pick;
    logic             int_stb;
    logic             ext_stb;

    always_comb begin
        ref_pick = ref_alt ? alt_tick_i : ref_tick_i;
        int_stb  = clk_en && ref_pick && (cnt == div) && !restart;
        ext_stb  = ext_bclk_i && !ext_q;
        bit_stb  = ext_clk ? ext_stb : int_stb;
        active   = ext_clk || clk_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            ext_q      <= 1'b0;
            bclk_pulse <= 1'b0;
        end else begin
            ext_q      <= ext_bclk_i;
            bclk_pulse <= bit_stb && !restart;
            if (!clk_en || restart) begin
                cnt <= '0;
            end else if (ref_pick) begin
                cnt <= (cnt == div) ? '0 : cnt + 1'b1;
            end
        end
    end

    // R1: an undivided reference turns every tick into a bit strobe
    assert_div_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_clk && clk_en && div == '0 && ref_pick && !restart) |-> bit_stb);

    // R3: a gated internal clock produces no pulse in the next cycle
    assert_gate_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_clk && !clk_en) |=> !bclk_pulse);
endmodule

// File: rtl/pcm_frame_ctr.sv
module pcm_frame_ctr
    import pcm_fs_pkg::*;
#(
    parameter int P_BIT_W    = 3,
    parameter int P_SLOT_W   = 5,
    parameter int P_MODE_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_stb,
    input  logic                active,
    input  logic                restart,
    input  logic                ext_fs,
    input  logic                long_fs,
    input  logic                fs_low,
    input  logic                ext_fsync_i,
    input  logic [P_MODE_W-1:0] slot_mode,
    output logic [P_BIT_W-1:0]  bit_idx,
    output logic [P_SLOT_W-1:0] slot_idx,
    output logic [P_SLOT_W-1:0] slot_last,
    output logic                run
);
    localparam int              MAX_MODE = (1 << P_MODE_W) - 1;
    localparam logic [P_BIT_W-1:0] BIT_LAST = '1;

    fr_state_e st, st_d;
    logic      fs_prev;
    logic      fs_act_in;
    logic      fs_hit;

    always_comb begin
        slot_last = '1;
        slot_last = slot_last >> (MAX_MODE - int'(slot_mode));
        fs_act_in = ext_fsync_i ^ fs_low;
        fs_hit    = bit_stb && fs_act_in && !fs_prev;
        run       = (st == ST_RUN);
    end

    // next-state logic
    always_comb begin
        st_d = st;
        unique case (st)
            ST_IDLE: begin
                if (active) begin
                    if (ext_fs)       st_d = ST_SYNC;
                    else if (bit_stb) st_d = ST_RUN;
                end
            end
            ST_SYNC: begin
                if (!ext_fs)     st_d = ST_IDLE;
                else if (fs_hit) st_d = ST_RUN;
            end
            ST_RUN:  st_d = ST_RUN;
            default: st_d = ST_IDLE;
        endcase
        if (restart || !active) st_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_d;
    end

    // position counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx  <= '0;
            slot_idx <= '0;
            fs_prev  <= 1'b0;
        end else begin
            if (bit_stb) fs_prev <= fs_act_in;
            if (restart || !active) begin
                bit_idx  <= '0;
                slot_idx <= '0;
            end else begin
                unique case (st)
                    ST_IDLE: begin
                        if (!ext_fs && bit_stb) begin
                            bit_idx  <= BIT_LAST;
                            slot_idx <= slot_last;
                        end
                    end
                    ST_SYNC: begin
                        if (ext_fs && fs_hit) begin
                            bit_idx  <= long_fs ? '0 : BIT_LAST;
                            slot_idx <= long_fs ? '0 : slot_last;
                        end
                    end
                    ST_RUN: begin
                        if (bit_stb) begin
                            if (ext_fs && fs_hit) begin
                                bit_idx  <= long_fs ? '0 : BIT_LAST;
                                slot_idx <= long_fs ? '0 : slot_last;
                            end else if (bit_idx == BIT_LAST) begin
                                bit_idx  <= '0;
                                slot_idx <= (slot_idx == slot_last) ? '0 : slot_idx + 1'b1;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                    end
                    default: begin
                        bit_idx  <= '0;
                        slot_idx <= '0;
                    end
                endcase
            end
        end
    end

    // R6: a strobe inside a running frame steps the bit index by one
    assert_bit_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && bit_stb && active && !restart && !fs_hit)
        |=> bit_idx == $past(bit_idx) + 1'b1);

    // R6: without a strobe the position holds
    assert_idx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_stb && active && !restart) |=> ($stable(bit_idx) && $stable(slot_idx)));

    // R6: the slot index never passes the last slot of the mode
    assert_slot_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        slot_idx <= slot_last);
endmodule

// File: rtl/pcm_fsync_shape.sv
module pcm_fsync_shape #(
    parameter int P_BIT_W  = 3,
    parameter int P_SLOT_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [P_BIT_W-1:0]  bit_idx,
    input  logic [P_SLOT_W-1:0] slot_idx,
    input  logic [P_SLOT_W-1:0] slot_last,
    input  logic                long_fs,
    input  logic                fs_low,
    input  logic                ext_fs,
    input  logic                tri_en,
    input  logic                bclk_pulse,
    output logic                fsync_o,
    output logic                fsync_oe,
    output logic                dtx_oe
);
    localparam logic [P_BIT_W-1:0] BIT_LAST = '1;

    logic fs_int;

    always_comb begin
        if (long_fs) fs_int = run && (slot_idx == '0);
        else         fs_int = run && (bit_idx == BIT_LAST) && (slot_idx == slot_last);
        fsync_oe = !ext_fs;
        fsync_o  = ext_fs ? 1'b0 : (fs_int ^ fs_low);
        dtx_oe   = run && !(tri_en && (bit_idx == BIT_LAST) && !bclk_pulse);
    end

    // R10: the data line is only released after the bit-clock pulse falls
    assert_tri_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dtx_oe) && run && $past(run)) |-> $past(bclk_pulse));

    // R9: an undriven frame-sync pin is held low
    assert_fsync_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fsync_oe |-> !fsync_o);
endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
    import pcm_fs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              ref_tick_i,
    input  logic              alt_tick_i,
    input  logic              ext_bclk_i,
    input  logic              ext_fsync_i,
    output logic              bclk_o,
    output logic              fsync_o,
    output logic              fsync_oe,
    output logic              dtx_oe,
    output logic [BIT_W-1:0]  bit_idx,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              frame_run
);
    clk_cfg_t          ccfg;
    frm_cfg_t          fcfg;
    clk_cfg_t          ccfg_new;
    frm_cfg_t          fcfg_new;
    logic              restart;
    logic              bit_stb;
    logic              active;
    logic              bclk_pulse;
    logic [SLOT_W-1:0] slot_last;

    always_comb begin
        ccfg_new = clk_cfg_t'(cfg_wdata[$bits(clk_cfg_t)-1:0]);
        fcfg_new = frm_cfg_t'(cfg_wdata[$bits(frm_cfg_t)-1:0]);
        restart  = cfg_wr && (cfg_addr ? (fcfg_new.slot_mode != fcfg.slot_mode)
                                       : (ccfg_new.div != ccfg.div));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccfg <= '0;
            fcfg <= '0;
        end else if (cfg_wr) begin
            if (cfg_addr) fcfg <= fcfg_new;
            else          ccfg <= ccfg_new;
        end
    end

    pcm_bclk_src #(.DIV_W(DIV_W)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick_i (ref_tick_i),
        .alt_tick_i (alt_tick_i),
        .ref_alt    (ccfg.ref_alt),
        .div        (ccfg.div),
        .clk_en     (ccfg.clk_en),
        .ext_clk    (fcfg.ext_clk),
        .ext_bclk_i (ext_bclk_i),
        .restart    (restart),
        .bit_stb    (bit_stb),
        .active     (active),
        .bclk_pulse (bclk_pulse)
    );

    pcm_frame_ctr #(.P_BIT_W(BIT_W), .P_SLOT_W(SLOT_W), .P_MODE_W(MODE_W)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb     (bit_stb),
        .active      (active),
        .restart     (restart),
        .ext_fs      (fcfg.ext_fs),
        .long_fs     (fcfg.long_fs),
        .fs_low      (fcfg.fs_low),
        .ext_fsync_i (ext_fsync_i),
        .slot_mode   (fcfg.slot_mode),
        .bit_idx     (bit_idx),
        .slot_idx    (slot_idx),
        .slot_last   (slot_last),
        .run         (frame_run)
    );

    pcm_fsync_shape #(.P_BIT_W(BIT_W), .P_SLOT_W(SLOT_W)) u_shape (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (frame_run),
        .bit_idx    (bit_idx),
        .slot_idx   (slot_idx),
        .slot_last  (slot_last),
        .long_fs    (fcfg.long_fs),
        .fs_low     (fcfg.fs_low),
        .ext_fs     (fcfg.ext_fs),
        .tri_en     (fcfg.tri_en),
        .bclk_pulse (bclk_pulse),
        .fsync_o    (fsync_o),
        .fsync_oe   (fsync_oe),
        .dtx_oe     (dtx_oe)
    );

    assign bclk_o = bclk_pulse && fcfg.clkout_en;

    // R11: a restart leaves the frame stopped in the following cycle
    assert_restart_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !frame_run);

    // R5: with the clock output disabled the pin stays low
    assert_clkout_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fcfg.clkout_en |-> !bclk_o);
endmodule

// File: tb/pcm_frame_timer_bench.sv
`timescale 1ns/1ps
module pcm_frame_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_addr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       ref_tick_i = 1'b1;
    logic       alt_tick_i = 1'b0;
    logic       ext_bclk_i = 1'b0;
    logic       ext_fsync_i = 1'b0;
    logic       bclk_o, fsync_o, fsync_oe, dtx_oe, frame_run;
    logic [2:0] bit_idx;
    logic [4:0] slot_idx;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    bit  alt_run = 0;
    bit  ext_run = 0;
    int  ext_ph = 0;

    always #2 clk = ~clk;

    pcm_frame_timer u_pcm_frame_timer (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ref_tick_i(ref_tick_i), .alt_tick_i(alt_tick_i),
        .ext_bclk_i(ext_bclk_i), .ext_fsync_i(ext_fsync_i), .bclk_o(bclk_o),
        .fsync_o(fsync_o), .fsync_oe(fsync_oe), .dtx_oe(dtx_oe),
        .bit_idx(bit_idx), .slot_idx(slot_idx), .frame_run(frame_run)
    );

    always @(negedge clk) begin
        alt_tick_i <= alt_run ? ~alt_tick_i : 1'b0;
        if (ext_run) begin
            ext_ph     <= (ext_ph == 5) ? 0 : ext_ph + 1;
            ext_bclk_i <= (ext_ph < 3);
        end else begin
            ext_ph     <= 0;
            ext_bclk_i <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    function automatic logic [7:0] frm(input int mode, input bit tri_b, input bit low,
                                       input bit lng, input bit extfs, input bit clkout,
                                       input bit extclk);
        return {mode[1:0], tri_b, low, lng, extfs, clkout, extclk};
    endfunction

    task automatic measure(input int per, input int fbits, input bit lng, input bit low,
                           input bit tri_b, input int np);
        int k = 0;
        int t = 0;
        int last_t = 0;
        int expi = 0;
        while (k < np) begin
            @(negedge clk);
            t++;
            if (bclk_o) begin
                expi = (k + fbits - 1) % fbits;
                if (k > 0) chk(t - last_t == per, "R1 bit period", t - last_t, per);
                chk(int'(bit_idx) == expi % 8, "R6 bit index", int'(bit_idx), expi % 8);
                chk(int'(slot_idx) == expi / 8, "R6 slot index", int'(slot_idx), expi / 8);
                chk(fsync_o == ((lng ? (expi / 8 == 0) : (expi == fbits - 1)) ^ low),
                    "R7_R8 frame sync", int'(fsync_o),
                    int'((lng ? (expi / 8 == 0) : (expi == fbits - 1)) ^ low));
                chk(dtx_oe == 1'b1, "R10 enable at pulse", int'(dtx_oe), 1);
                last_t = t;
                k++;
            end else if (k > 0) begin
                chk(dtx_oe == !(tri_b && (expi % 8 == 7)), "R10 enable between pulses",
                    int'(dtx_oe), int'(!(tri_b && (expi % 8 == 7))));
            end
        end
    endtask

    task automatic next_pulse();
        do @(negedge clk); while (!bclk_o);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt_p;
        int cnt_r;
        int changes;
        logic [2:0] prev_bit;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: reset state
        chk(bclk_o == 0, "R3 reset bclk", int'(bclk_o), 0);
        chk(fsync_o == 0, "R3 reset fsync", int'(fsync_o), 0);
        chk(fsync_oe == 1, "R3 reset fsync_oe", int'(fsync_oe), 1);
        chk(dtx_oe == 0 && frame_run == 0, "R3 reset run", int'(frame_run), 0);

        // R3: gated clock
        wr(1'b1, frm(0, 0, 0, 0, 0, 1, 0));
        wr(1'b0, {1'b0, 1'b0, 6'd1});
        cnt_p = 0; cnt_r = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (bclk_o) cnt_p++;
            if (frame_run || dtx_oe) cnt_r++;
        end
        chk(cnt_p == 0, "R3 gated pulses", cnt_p, 0);
        chk(cnt_r == 0, "R3 gated run", cnt_r, 0);

        // R1 R6 R7 R8 R10 R12: sweep of divider, slot mode, width and polarity
        for (int d = 1; d <= 3; d += 2) begin
            for (int m = 0; m < 4; m++) begin
                for (int lg = 0; lg < 2; lg++) begin
                    for (int lw = 0; lw < 2; lw++) begin
                        bit tb = bit'((m + lg) % 2);
                        wr(1'b0, {1'b0, 1'b0, 6'(d)});
                        wr(1'b1, frm(m, tb, bit'(lw), bit'(lg), 0, 1, 0));
                        wr(1'b0, {1'b1, 1'b0, 6'(d)});
                        measure(d + 1, 32 << m, bit'(lg), bit'(lw), tb, (32 << m) * 2 + 2);
                    end
                end
            end
        end

        // R2: alternate reference ticks every other cycle
        alt_run = 1;
        wr(1'b0, {1'b0, 1'b1, 6'd0});
        wr(1'b1, frm(0, 0, 0, 0, 0, 1, 0));
        wr(1'b0, {1'b1, 1'b1, 6'd0});
        measure(2, 32, 0, 0, 0, 10);
        wr(1'b0, {1'b0, 1'b1, 6'd1});
        wr(1'b0, {1'b1, 1'b1, 6'd1});
        measure(4, 32, 0, 0, 0, 10);
        alt_run = 0;

        // R1: divider 60 gives a 61-cycle bit period
        wr(1'b0, {1'b0, 1'b0, 6'd60});
        wr(1'b0, {1'b1, 1'b0, 6'd60});
        measure(61, 32, 0, 0, 0, 4);

        // R5: clock output off, counters still advance
        wr(1'b1, frm(0, 0, 0, 0, 0, 0, 0));
        cnt_p = 0; changes = 0; prev_bit = bit_idx;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (bclk_o) cnt_p++;
            if (bit_idx != prev_bit) changes++;
            prev_bit = bit_idx;
        end
        chk(cnt_p == 0, "R5 pulses hidden", cnt_p, 0);
        chk(changes >= 4, "R5 counting", changes, 4);

        // R11: divider change restarts the frame
        wr(1'b1, frm(0, 0, 0, 0, 0, 1, 0));
        wr(1'b0, {1'b1, 1'b0, 6'd3});
        repeat (50) @(negedge clk);
        wr(1'b0, {1'b1, 1'b0, 6'd2});
        measure(3, 32, 0, 0, 0, 12);
        // R11: slot mode change restarts the frame
        repeat (37) @(negedge clk);
        wr(1'b1, frm(1, 0, 0, 0, 0, 1, 0));
        measure(3, 64, 0, 0, 0, 12);

        // R4: external bit clock, clock enable off
        wr(1'b0, {1'b0, 1'b0, 6'd3});
        ext_run = 1;
        wr(1'b1, frm(0, 0, 0, 0, 0, 1, 1));
        measure(6, 32, 0, 0, 0, 70);
        ext_run = 0;
        wr(1'b1, frm(0, 0, 0, 0, 0, 1, 0));

        // R9: external frame sync, short then long
        wr(1'b0, {1'b0, 1'b0, 6'd3});
        wr(1'b1, frm(0, 0, 0, 0, 1, 1, 0));
        wr(1'b0, {1'b1, 1'b0, 6'd3});
        repeat (20) @(negedge clk);
        chk(frame_run == 0, "R9 waits for sync", int'(frame_run), 0);
        chk(fsync_oe == 0, "R9 pin released", int'(fsync_oe), 0);
        chk(fsync_o == 0, "R9 pin low", int'(fsync_o), 0);
        next_pulse();
        ext_fsync_i = 1'b1;
        next_pulse();
        chk(frame_run == 1, "R9 running", int'(frame_run), 1);
        chk(bit_idx == 3'd7 && slot_idx == 5'd3, "R9 short align",
            int'({slot_idx, bit_idx}), int'({5'd3, 3'd7}));
        ext_fsync_i = 1'b0;
        next_pulse();
        chk(bit_idx == 3'd0 && slot_idx == 5'd0, "R9 frame start",
            int'({slot_idx, bit_idx}), 0);
        wr(1'b1, frm(0, 0, 0, 1, 1, 1, 0));
        next_pulse();
        ext_fsync_i = 1'b1;
        next_pulse();
        chk(bit_idx == 3'd0 && slot_idx == 5'd0, "R9 long align",
            int'({slot_idx, bit_idx}), 0);
        ext_fsync_i = 1'b0;
        next_pulse();
        chk(bit_idx == 3'd1 && slot_idx == 5'd0, "R9 long advance",
            int'({slot_idx, bit_idx}), 1);
        chk(fsync_o == 0, "R9 pin low running", int'(fsync_o), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule